// File: doc/BRIEF.md
# Two-Channel Result Pairing Corrector

This block sits behind the serial receiver of a two-channel delta-sigma converter that alternates its input on every conversion. The receiver delivers each 32-bit result word with a valid strobe. The block decodes the word's sign, extended-range and magnitude fields into a signed fixed-point number and clamps it to the converter's legal span. It then uses the channel bit carried inside each word to join a channel-0 result with the channel-1 result that follows it.

Each completed pair yields one corrected value. In difference mode the value is channel 0 minus channel 1, which gives a pseudo-differential bridge reading. In sum mode the two are added, so that equal and opposite lead drops in a remote resistive sensor cancel. Corrected pairs are averaged over a power-of-two window before they leave the block. Range flags report any frame in the window that lay outside the normal span. A separate pulse reports a broken channel sequence.

Values are in units of one sub-LSB. Full scale is 2^28 with the default widths, which are a 24-bit magnitude and 4 sub-LSB bits. Bit 31 of a frame is the busy bit, bit 30 the channel, bit 29 the sign, bit 28 the extended-range bit, and bits 27..0 the magnitude including the sub-LSBs.

Top module: `pair_corrector`

## Requirements
- R1: A frame with sign bit 1 decodes to the non-negative value ext*2^28 + magnitude, where ext is bit 28 and the magnitude is bits 27..0.
- R2: A frame with sign bit 0 and ext 1 decodes to magnitude - 2^28, a 28-bit two's complement negative. A frame with sign 0 and ext 0 is a negative zero and decodes to 0.
- R3: Decoded values are clamped to the range -2^25 to 9*2^25, which is -1/8 to +9/8 of full scale.
- R4: When sum_mode is 0 at the time a pair completes, the pair value is the channel-0 value minus the channel-1 value.
- R5: When sum_mode is 1 at the time a pair completes, the pair value is the channel-0 value plus the channel-1 value.
- R6: Bit 30 selects the channel (0 is CH0, 1 is CH1). A CH1 frame that arrives while a CH0 frame is held completes a pair. Frames are presented with bit 31 low, and any number of idle cycles may separate frames.
- R7: A CH0 frame that arrives while a CH0 frame is already held replaces the held one, and seq_err pulses for one cycle.
- R8: A CH1 frame that arrives with no CH0 frame held is discarded, and seq_err pulses for one cycle.
- R9: Every 2^AVG_LOG2 pairs (4 by default), res_valid pulses for one cycle. res_value is the sum of the pairs in the window shifted right arithmetically by AVG_LOG2, which rounds toward minus infinity.
- R10: res_over is set when any frame in the window had sign 1 and ext 1. res_under is set when any frame in the window had sign 0 and ext 1.
- R11: After reset, res_valid and seq_err are low and no CH0 frame is held.
- R12: seq_err is valid in the cycle after the offending frame. res_valid is valid two cycles after the CH1 frame that completes a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_valid | input | 1 | Frame strobe |
| frame_data | input | 32 | Converter result word |
| sum_mode | input | 1 | 1 selects sum, 0 selects difference |
| res_valid | output | 1 | Averaged result strobe |
| res_value | output | 31 | Signed averaged corrected value |
| res_over | output | 1 | A frame in the window was above full scale |
| res_under | output | 1 | A frame in the window was below zero |
| seq_err | output | 1 | Channel sequence error pulse |

## Verification
A frame sampled at clock edge k sets seq_err at that same edge, so the pulse is visible for the whole cycle after edge k. The same edge loads the pair register. The averaging register takes the pair at edge k+1, so a window result is visible one cycle later than seq_err. The bench model follows this timing. At every step it first advances its averager on the pair from the previous step, then processes the current frame. It compares seq_err and the result outputs one nanosecond after each rising edge, so a result that arrives one cycle early or late shows up as a mismatch.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
   // field offsets above the magnitude field inside a result word
   localparam int EXT_OFS  = 0;
   localparam int SIG_OFS  = 1;
   localparam int CH_OFS   = 2;
   localparam int BUSY_OFS = 3;

   typedef struct packed {
      logic over;
      logic under;
   } pcr_flags_t;
endpackage

// File: rtl/pcr_decode.sv
module pcr_decode
   import pcr_pkg::*;
#(
   parameter int RAW_W    = 28,
   parameter int SUB_W    = 4,
   parameter int KEEP_SUB = 1,
   parameter int VAL_W    = RAW_W + 2
) (
   input  logic [RAW_W+2:0]       word_i,
   output logic                   ch_o,
   output logic signed [VAL_W-1:0] val_o,
   output pcr_flags_t             flg_o
);
   localparam int RW = RAW_W + 2;
   localparam logic signed [RW-1:0] LIM_HI = {2'b01, 3'b001, {(RAW_W-3){1'b0}}};
   localparam logic signed [RW-1:0] LIM_LO = {5'b11111, {(RAW_W-3){1'b0}}};

   logic                 sgn, ext;
   logic [RAW_W-1:0]     mag;
   logic signed [RW-1:0] raw, lim;

   assign mag  = word_i[RAW_W-1:0];
   assign ext  = word_i[RAW_W+EXT_OFS];
   assign sgn  = word_i[RAW_W+SIG_OFS];
   assign ch_o = word_i[RAW_W+CH_OFS];

   assign flg_o.over  = sgn & ext;
   assign flg_o.under = ~sgn & ext;

   always_comb begin
      if (!sgn && !ext) raw = '0;
      else              raw = {~sgn & ext, ext, mag};
      if (raw > LIM_HI)      lim = LIM_HI;
      else if (raw < LIM_LO) lim = LIM_LO;
      else                   lim = raw;
   end

   generate
      if (KEEP_SUB != 0) begin : g_keep
         assign val_o = lim;
      end else begin : g_drop
         assign val_o = VAL_W'(lim >>> SUB_W);
      end
   endgenerate
endmodule

// File: rtl/pcr_pair.sv
module pcr_pair
   import pcr_pkg::*;
#(
   parameter int VAL_W = 30,
   parameter int PW    = VAL_W + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic                    ch,
   input  logic signed [VAL_W-1:0] val,
   input  pcr_flags_t              flg,
   input  logic                    sum_mode,
   output logic                    pr_valid,
   output logic signed [PW-1:0]    pr_val,
   output pcr_flags_t              pr_flg,
   output logic                    seq_err
);
   logic                    have;
   logic signed [VAL_W-1:0] hold_val;
   pcr_flags_t              hold_flg;
   logic signed [PW-1:0]    a_x, b_x;

   assign a_x = {hold_val[VAL_W-1], hold_val};
   assign b_x = {val[VAL_W-1], val};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         have     <= 1'b0;
         hold_val <= '0;
         hold_flg <= '0;
         pr_valid <= 1'b0;
         pr_val   <= '0;
         pr_flg   <= '0;
         seq_err  <= 1'b0;
      end else begin
         pr_valid <= 1'b0;
         seq_err  <= 1'b0;
         if (in_valid) begin
            if (!ch) begin
               seq_err  <= have;
               have     <= 1'b1;
               hold_val <= val;
               hold_flg <= flg;
            end else if (have) begin
               pr_valid     <= 1'b1;
               pr_val       <= sum_mode ? (a_x + b_x) : (a_x - b_x);
               pr_flg.over  <= hold_flg.over | flg.over;
               pr_flg.under <= hold_flg.under | flg.under;
               have         <= 1'b0;
            end else begin
               seq_err <= 1'b1;
            end
         end
      end
   end

   p_pair_fires_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ch && have) |=> (pr_valid && !seq_err));
   p_repeat_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !ch && have) |=> (seq_err && !pr_valid));
   p_orphan_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ch && !have) |=> (seq_err && !pr_valid));
   p_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!seq_err && !pr_valid));
endmodule

// File: rtl/pcr_avg.sv
module pcr_avg
   import pcr_pkg::*;
#(
   parameter int PW       = 31,
   parameter int AVG_LOG2 = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic signed [PW-1:0] in_val,
   input  pcr_flags_t           in_flg,
   output logic                 out_valid,
   output logic signed [PW-1:0] out_val,
   output pcr_flags_t           out_flg
);
   localparam int AW = PW + AVG_LOG2;

   generate
      if (AVG_LOG2 == 0) begin : g_pass
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               out_valid <= 1'b0;
               out_val   <= '0;
               out_flg   <= '0;
            end else begin
               out_valid <= in_valid;
               if (in_valid) begin
                  out_val <= in_val;
                  out_flg <= in_flg;
               end
            end
         end
      end else begin : g_win
         logic [AVG_LOG2-1:0]  cnt;
         logic signed [AW-1:0] acc, nxt;
         pcr_flags_t           wf;

         assign nxt = acc + {{AVG_LOG2{in_val[PW-1]}}, in_val};

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt       <= '0;
               acc       <= '0;
               wf        <= '0;
               out_valid <= 1'b0;
               out_val   <= '0;
               out_flg   <= '0;
            end else begin
               out_valid <= 1'b0;
               if (in_valid) begin
                  if (&cnt) begin
                     out_valid     <= 1'b1;
                     out_val       <= PW'(nxt >>> AVG_LOG2);
                     out_flg.over  <= wf.over | in_flg.over;
                     out_flg.under <= wf.under | in_flg.under;
                     acc           <= '0;
                     cnt           <= '0;
                     wf            <= '0;
                  end else begin
                     acc      <= nxt;
                     cnt      <= cnt + 1'b1;
                     wf.over  <= wf.over | in_flg.over;
                     wf.under <= wf.under | in_flg.under;
                  end
               end
            end
         end

         p_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !(&cnt)) |=> !out_valid);
      end
   endgenerate

   p_out_after_pair_r12: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));
endmodule

// File: rtl/pair_corrector.sv
module pair_corrector
   import pcr_pkg::*;
#(
   parameter int MAG_W    = 24,
   parameter int SUB_W    = 4,
   parameter int KEEP_SUB = 1,
   parameter int AVG_LOG2 = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    frame_valid,
   input  logic [MAG_W+SUB_W+3:0]  frame_data,
   input  logic                    sum_mode,
   output logic                    res_valid,
   output logic signed [MAG_W+SUB_W+2-((KEEP_SUB != 0) ? 0 : SUB_W):0] res_value,
   output logic                    res_over,
   output logic                    res_under,
   output logic                    seq_err
);
   localparam int RAW_W = MAG_W + SUB_W;
   localparam int VAL_W = RAW_W + 2 - ((KEEP_SUB != 0) ? 0 : SUB_W);
   localparam int PW    = VAL_W + 1;

   generate
      if (MAG_W < 4 || MAG_W > 40) begin : g_bad_mag
         $error("pair_corrector: MAG_W out of range");
      end
      if (SUB_W < 0 || SUB_W > 8) begin : g_bad_sub
         $error("pair_corrector: SUB_W out of range");
      end
      if (AVG_LOG2 < 0 || AVG_LOG2 > 16) begin : g_bad_avg
         $error("pair_corrector: AVG_LOG2 out of range");
      end
   endgenerate

   logic                    d_ch;
   logic signed [VAL_W-1:0] d_val;
   pcr_flags_t              d_flg;
   logic                    p_valid;
   logic signed [PW-1:0]    p_val;
   pcr_flags_t              p_flg;
   pcr_flags_t              o_flg;

   pcr_decode #(
      .RAW_W(RAW_W), .SUB_W(SUB_W), .KEEP_SUB(KEEP_SUB), .VAL_W(VAL_W)
   ) u_dec (
      .word_i(frame_data[RAW_W+2:0]),
      .ch_o  (d_ch),
      .val_o (d_val),
      .flg_o (d_flg)
   );

   pcr_pair #(.VAL_W(VAL_W), .PW(PW)) u_pair (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_valid(frame_valid),
      .ch      (d_ch),
      .val     (d_val),
      .flg     (d_flg),
      .sum_mode(sum_mode),
      .pr_valid(p_valid),
      .pr_val  (p_val),
      .pr_flg  (p_flg),
      .seq_err (seq_err)
   );

   pcr_avg #(.PW(PW), .AVG_LOG2(AVG_LOG2)) u_avg (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (p_valid),
      .in_val   (p_val),
      .in_flg   (p_flg),
      .out_valid(res_valid),
      .out_val  (res_value),
      .out_flg  (o_flg)
   );

   assign res_over  = o_flg.over;
   assign res_under = o_flg.under;

   p_busy_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |-> !frame_data[RAW_W+BUSY_OFS]);
   p_err_vs_result_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seq_err) |-> $past(frame_valid));
endmodule

// File: tb/sim_pair_corrector.sv
module sim_pair_corrector;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        frame_valid;
   logic [31:0] frame_data;
   logic        sum_mode;
   logic        res_valid;
   logic signed [30:0] res_value;
   logic        res_over, res_under, seq_err;

   always #2 clk = ~clk;

   pair_corrector u0 (
      .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_data(frame_data),
      .sum_mode(sum_mode), .res_valid(res_valid), .res_value(res_value),
      .res_over(res_over), .res_under(res_under), .seq_err(seq_err)
   );

   int    checks = 0;
   int    errors = 0;
   string tag = "R11";

   // reference model state
   bit     have = 0, ho = 0, hu = 0;
   longint hv = 0;
   bit     pv = 0, po = 0, pu = 0;
   longint pval = 0;
   longint acc = 0;
   int     cnt = 0;
   bit     wo = 0, wu = 0;

   function automatic logic [31:0] mk(bit ch, bit sg, bit ex, logic [27:0] mag);
      return {1'b0, ch, sg, ex, mag};
   endfunction

   function automatic logic [31:0] mkv(bit ch, longint v);
      logic [63:0] u;
      u = v;
      if (v >= 0) return mk(ch, 1'b1, v >= 64'sd268435456, u[27:0]);
      return mk(ch, 1'b0, 1'b1, u[27:0]);
   endfunction

   function automatic longint dec(logic [31:0] f);
      longint r;
      if (f[29])      r = (f[28] ? 64'sd268435456 : 64'sd0) + longint'(f[27:0]);
      else if (f[28]) r = longint'(f[27:0]) - 64'sd268435456;
      else            r = 0;
      if (r > 64'sd301989888) r = 64'sd301989888;
      if (r < -64'sd33554432) r = -64'sd33554432;
      return r;
   endfunction

   task automatic chk(bit ok, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic step(bit v, logic [31:0] f, bit m);
      bit     e_ov, e_err, e_o, e_u;
      longint e_val, dv;
      bit     fo, fu;
      @(negedge clk);
      frame_valid = v; frame_data = f; sum_mode = m;
      @(posedge clk);
      #1;
      e_ov = 0; e_val = 0; e_o = 0; e_u = 0;
      if (pv) begin
         acc += pval; wo |= po; wu |= pu;
         if (cnt == 3) begin
            e_ov = 1; e_val = acc >>> 2; e_o = wo; e_u = wu;
            acc = 0; cnt = 0; wo = 0; wu = 0;
         end else cnt++;
      end
      pv = 0; e_err = 0;
      if (v) begin
         dv = dec(f); fo = f[29] & f[28]; fu = ~f[29] & f[28];
         if (!f[30]) begin
            if (have) e_err = 1;
            have = 1; hv = dv; ho = fo; hu = fu;
         end else if (have) begin
            pv = 1; pval = m ? hv + dv : hv - dv; po = ho | fo; pu = hu | fu; have = 0;
         end else e_err = 1;
      end
      chk(seq_err == e_err, "seq_err", longint'(seq_err), longint'(e_err));
      chk(res_valid == e_ov, "res_valid", longint'(res_valid), longint'(e_ov));
      if (e_ov) begin
         chk(longint'(res_value) == e_val, "res_value", longint'(res_value), e_val);
         chk(res_over == e_o, "res_over", longint'(res_over), longint'(e_o));
         chk(res_under == e_u, "res_under", longint'(res_under), longint'(e_u));
      end
   endtask

   task automatic pairs4(logic [31:0] f0, logic [31:0] f1, bit m);
      for (int i = 0; i < 4; i++) begin
         step(1, f0, m);
         step(1, f1, m);
      end
      step(0, '0, m);
      step(0, '0, m);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired: actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; frame_valid = 1'b0; frame_data = '0; sum_mode = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #0;
      tag = "R11";
      chk(res_valid == 0, "reset res_valid", longint'(res_valid), 0);
      chk(seq_err == 0, "reset seq_err", longint'(seq_err), 0);
      // a CH1 right after reset must be an orphan (nothing held)
      step(1, mkv(1, 5), 1);
      step(0, '0, 0);

      tag = "R1";
      pairs4(mkv(0, 64'sd19088743), mkv(1, 0), 1);
      pairs4(mkv(0, 64'sd268435461), mkv(1, 0), 1);
      tag = "R2";
      pairs4(mkv(0, -1), mkv(1, 0), 1);
      pairs4(mk(0, 0, 0, 28'h0), mkv(1, 7), 1);
      tag = "R3";
      pairs4(mk(0, 1, 1, 28'hF000000), mkv(1, 0), 1);
      pairs4(mk(0, 0, 1, 28'h0), mkv(1, 0), 1);
      tag = "R4";
      pairs4(mkv(0, 1000), mkv(1, 300), 0);
      pairs4(mkv(0, -2000), mkv(1, 64'sd301989888), 0);
      tag = "R5";
      pairs4(mkv(0, 5000), mkv(1, -1200), 1);
      tag = "R7";
      step(1, mkv(0, 999), 0);
      step(1, mkv(0, 40), 0);
      step(1, mkv(1, 10), 0);
      tag = "R8";
      step(1, mkv(1, 77), 0);
      step(1, mkv(1, 78), 0);
      tag = "R9";
      step(1, mkv(0, 0), 0); step(1, mkv(1, 1), 0);
      step(1, mkv(0, 0), 0); step(1, mkv(1, 0), 0);
      step(1, mkv(0, 3), 0); step(1, mkv(1, 3), 0);
      step(0, '0, 0); step(0, '0, 0);
      tag = "R10";
      step(1, mk(0, 0, 1, 28'hFFFFFF0), 1); step(1, mkv(1, 5), 1);
      step(1, mkv(0, 8), 1); step(1, mk(1, 1, 1, 28'h10), 1);
      step(0, '0, 0); step(0, '0, 0);
      tag = "R12";
      for (int i = 0; i < 8; i++) begin
         step(1, mkv(i[0], longint'(i) * 1000), i[1]);
         repeat (i % 3) step(0, '0, 0);
      end
      tag = "R6";
      for (int i = 0; i < 400; i++) begin
         bit ch;
         longint v;
         ch = ($urandom_range(0, 9) == 0) ? ~i[0] : i[0];
         v = longint'($urandom_range(0, 32'd335544320)) - 64'sd33554432;
         step($urandom_range(0, 4) != 0, mkv(ch, v), $urandom_range(0, 1) == 1);
      end
      repeat (4) step(0, '0, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule